// File: doc/BRIEF.md
# Language Card Bank Controller

This block controls the 16 KB bank-switched RAM that can stand in for the system ROM in the top 12 KB of a 16-bit address space (window `$D000`–`$FFFF`). Any bus access to one of sixteen switch addresses starting at `$C080` loads a small mode register. Two things are taken from the address: a bank choice for the lower 4 KB of the window, and one of four read/write combinations. On each access to the window, the block then tells the memory system three things. It says whether the read comes from ROM or RAM. It says whether a write may reach RAM. It gives the physical RAM address to use.

The lower 4 KB of the window has two RAM banks. Bank 2 sits at its natural physical offset. Bank 1 is moved 4 KB down, into the physical range that lies under the I/O space and is otherwise unreachable. The upper 8 KB is shared by both banks. An auxiliary-select input picks main or auxiliary RAM. It is carried as the most significant bit of the physical address.

Two status addresses report the mode in their flag bit: one gives the bank choice and the other gives the read source. Reads of the switch addresses raise a flag that tells the bus to return its floating value. The RAM and ROM arrays sit outside this block.

Top module: `lcbank_ctrl`

## Requirements
- R1: A valid read or write whose address lies in `$C080`–`$C08F` loads the mode register with the address ANDed with `0x0B` (address bits 3, 1, 0), in effect from the next cycle. Any other access, or a cycle with `bus_valid` low, leaves the mode unchanged.
- R2: Reset loads mode `0b0010`. In that mode, reads of the window come from ROM, writes to the window are blocked, and the bank choice is bank 2.
- R3: Mode bits [1:0] set the read source. With `00` or `11`, a window read asserts `ram_re` and leaves `rom_sel` low. With `01` or `10`, a window read asserts `rom_sel` and leaves `ram_re` low.
- R4: Mode bit 0 sets write permission. When it is 1 (modes `01` and `11`), a window write asserts `ram_we`. When it is 0, `ram_we` stays low and the write is dropped.
- R5: Mode bit 3 sets the bank for `$D000`–`$DFFF`. A value of 0 (bank 2) gives the physical address equal to the bus address. A value of 1 (bank 1) gives the bus address minus `$1000`, which lands in `$C000`–`$CFFF`.
- R6: For `$E000`–`$FFFF`, the physical address equals the bus address whichever bank is chosen, and the access follows the same read/write mode.
- R7: `ram_addr[16]` equals `alt_sel` on every window access (1 means auxiliary RAM, 0 means main RAM).
- R8: A valid read of `$C011` asserts `stat_hit`. `stat_data` bit 7 is then 1 when the mode value is below 4 (bank 2) and 0 otherwise, and all other bits are 0.
- R9: A valid read of `$C012` asserts `stat_hit`. `stat_data` bit 7 is then 1 when mode bits 0 and 1 are equal (RAM is read) and 0 otherwise, and all other bits are 0.
- R10: `float_bus` is 1 during a valid read of `$C080`–`$C08F`. It is 0 for writes to those addresses and for every other access.
- R11: Outside the window, or when `bus_valid` is low, `rom_sel`, `ram_re` and `ram_we` are all 0. Outputs are combinational from the current bus inputs and the registered mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | A bus access is present this cycle |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 16 | Bus address |
| alt_sel | input | 1 | 1 sends language-card RAM accesses to auxiliary RAM |
| rom_sel | output | 1 | A window read must be served by ROM |
| ram_re | output | 1 | A window read must be served by RAM |
| ram_we | output | 1 | A window write may update RAM |
| ram_addr | output | 17 | Physical RAM address, bit 16 = auxiliary select |
| stat_hit | output | 1 | A status read is being answered |
| stat_data | output | 8 | Status byte, flag in bit 7 |
| float_bus | output | 1 | The bus should return its floating value |

## Verification
The bench builds the block with its default parameters: a 16-bit address, an 8-bit status byte with the flag in bit 7, and the switch block at `$C080`. At this size every one of the sixteen switch addresses can be reached, each as both a read and a write. After each switch access, the bench covers the window edges and interior (`$D000`, `$D5A3`, `$DFFF`, `$E000`, `$FFFF`) as both reads and writes with both values of the auxiliary select, then reads both status addresses. This checks every mode against a model derived from the address arithmetic. Separate sequences check the reset mode, and check that near-miss addresses and idle cycles leave the mode untouched.

// File: rtl/lcb_pkg.sv
package lcb_pkg;

   // Read/write combination held in mode bits [1:0]
   typedef enum logic [1:0] {
      LCB_RAM_RD_NOWR = 2'b00,
      LCB_ROM_RD_WR   = 2'b01,
      LCB_ROM_RD_NOWR = 2'b10,
      LCB_RAM_RD_WR   = 2'b11
   } lcb_acc_e;

   typedef struct packed {
      logic     bank1_sel;   // mode bit 3: 1 = bank 1 in the low 4 KB
      lcb_acc_e acc;         // mode bits 1:0
   } lcb_mode_t;

   // Turn a switch-address nibble into a mode (bit 2 is masked away)
   function automatic lcb_mode_t lcb_decode(input logic [3:0] nib);
      lcb_mode_t m;
      m.bank1_sel = nib[3];
      m.acc       = lcb_acc_e'(nib[1:0]);
      return m;
   endfunction

   function automatic logic lcb_reads_ram(input lcb_mode_t m);
      return (m.acc == LCB_RAM_RD_NOWR) || (m.acc == LCB_RAM_RD_WR);
   endfunction

   function automatic logic lcb_writes_ram(input lcb_mode_t m);
      return (m.acc == LCB_ROM_RD_WR) || (m.acc == LCB_RAM_RD_WR);
   endfunction

endpackage

// File: rtl/lcb_mode_reg.sv
module lcb_mode_reg
   import lcb_pkg::*;
#(
   parameter int          ADDR_W     = 16,
   parameter int unsigned SW_BASE    = 32'hC080,
   parameter logic [3:0]  RESET_MODE = 4'b0010
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_valid,
   input  logic [ADDR_W-1:0] bus_addr,
   output logic              sw_hit,
   output lcb_mode_t         mode_q
);

   localparam logic [ADDR_W-1:0] SW_B = ADDR_W'(SW_BASE);

   if (SW_B[3:0] != 4'h0) begin : g_bad_base
      $error("lcb_mode_reg: SW_BASE must be 16-aligned");
   end
   if (RESET_MODE[2] != 1'b0) begin : g_bad_reset
      $error("lcb_mode_reg: RESET_MODE bit 2 must be 0");
   end

   assign sw_hit = (bus_addr[ADDR_W-1:4] == SW_B[ADDR_W-1:4]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= lcb_decode(RESET_MODE);
      end else if (bus_valid && sw_hit) begin
         mode_q <= lcb_decode(bus_addr[3:0]);
      end
   end

   AST_MODE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && bus_addr[ADDR_W-1:4] == SW_B[ADDR_W-1:4])
      |=> ({mode_q.bank1_sel, 1'b0, mode_q.acc} == ($past(bus_addr[3:0]) & 4'hB))); // R1

   AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_valid && bus_addr[ADDR_W-1:4] == SW_B[ADDR_W-1:4])
      |=> $stable(mode_q)); // R1

endmodule

// File: rtl/lcb_map.sv
module lcb_map
   import lcb_pkg::*;
#(
   parameter int          ADDR_W    = 16,
   parameter int unsigned WIN_BASE  = 32'hD000,
   parameter int unsigned BANK_SPAN = 32'h1000,
   localparam int         PA_W      = ADDR_W + 1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_valid,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              alt_sel,
   input  lcb_mode_t         mode_q,
   output logic              rom_sel,
   output logic              ram_re,
   output logic              ram_we,
   output logic [PA_W-1:0]   ram_addr
);

   localparam logic [ADDR_W-1:0] WIN_B  = ADDR_W'(WIN_BASE);
   localparam logic [ADDR_W-1:0] SPAN_B = ADDR_W'(BANK_SPAN);
   localparam logic [ADDR_W-1:0] HIGH_B = ADDR_W'(WIN_BASE + BANK_SPAN);

   if (WIN_BASE < BANK_SPAN || WIN_BASE + BANK_SPAN >= (1 << ADDR_W)) begin : g_bad_win
      $error("lcb_map: window does not fit the address space");
   end

   logic in_win, in_low, rd_ram, wr_ok;
   logic [ADDR_W-1:0] phys;

   always_comb begin
      in_win = bus_valid && (bus_addr >= WIN_B);
      in_low = (bus_addr >= WIN_B) && (bus_addr < HIGH_B);
      rd_ram = lcb_reads_ram(mode_q);
      wr_ok  = lcb_writes_ram(mode_q);
      phys   = (in_low && mode_q.bank1_sel) ? (bus_addr - SPAN_B) : bus_addr;
   end

   assign rom_sel  = in_win && !bus_we && !rd_ram;
   assign ram_re   = in_win && !bus_we && rd_ram;
   assign ram_we   = in_win && bus_we && wr_ok;
   assign ram_addr = {alt_sel, phys};

   AST_SRC_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(rom_sel && ram_re)); // R3

   AST_WE_ONLY_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |-> (bus_valid && bus_we && !rom_sel && !ram_re)); // R4

   AST_OUTSIDE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_valid || bus_addr < WIN_B) |-> !(rom_sel || ram_re || ram_we)); // R11

   AST_ALT_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_re || ram_we) |-> (ram_addr[PA_W-1] == alt_sel)); // R7

   AST_HIGH_IDENTITY: assert property (@(posedge clk) disable iff (!rst_n)
      ((ram_re || ram_we) && bus_addr >= HIGH_B)
      |-> (ram_addr[ADDR_W-1:0] == bus_addr)); // R6

endmodule

// File: rtl/lcb_status.sv
module lcb_status
   import lcb_pkg::*;
#(
   parameter int          ADDR_W    = 16,
   parameter int          DATA_W    = 8,
   parameter int          FLAG_BIT  = 7,
   parameter int unsigned BANK_STAT = 32'hC011,
   parameter int unsigned SRC_STAT  = 32'hC012
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_valid,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  lcb_mode_t         mode_q,
   output logic              stat_hit,
   output logic [DATA_W-1:0] stat_data
);

   localparam logic [ADDR_W-1:0] BANK_A = ADDR_W'(BANK_STAT);
   localparam logic [ADDR_W-1:0] SRC_A  = ADDR_W'(SRC_STAT);

   if (FLAG_BIT >= DATA_W || FLAG_BIT < 0) begin : g_bad_flag
      $error("lcb_status: FLAG_BIT outside DATA_W");
   end
   if (BANK_STAT == SRC_STAT) begin : g_bad_addr
      $error("lcb_status: status addresses must differ");
   end

   logic rd, bank_q, src_q, flag;

   always_comb begin
      rd     = bus_valid && !bus_we;
      bank_q = rd && (bus_addr == BANK_A);
      src_q  = rd && (bus_addr == SRC_A);
      flag   = bank_q ? !mode_q.bank1_sel : (src_q && lcb_reads_ram(mode_q));
   end

   assign stat_hit = bank_q || src_q;

   for (genvar gi = 0; gi < DATA_W; gi++) begin : g_bits
      if (gi == FLAG_BIT) begin : g_flag
         assign stat_data[gi] = flag;
      end else begin : g_zero
         assign stat_data[gi] = 1'b0;
      end
   end

   AST_STAT_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      stat_hit |-> (bus_valid && !bus_we)); // R8

   AST_STAT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !stat_hit |-> (stat_data == '0)); // R9

endmodule

// File: rtl/lcbank_ctrl.sv
module lcbank_ctrl
   import lcb_pkg::*;
#(
   parameter int          ADDR_W     = 16,
   parameter int          DATA_W     = 8,
   parameter int          FLAG_BIT   = 7,
   parameter int unsigned SW_BASE    = 32'hC080,
   parameter int unsigned WIN_BASE   = 32'hD000,
   parameter int unsigned BANK_SPAN  = 32'h1000,
   parameter int unsigned BANK_STAT  = 32'hC011,
   parameter int unsigned SRC_STAT   = 32'hC012,
   parameter logic [3:0]  RESET_MODE = 4'b0010
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_valid,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              alt_sel,
   output logic              rom_sel,
   output logic              ram_re,
   output logic              ram_we,
   output logic [ADDR_W:0]   ram_addr,
   output logic              stat_hit,
   output logic [DATA_W-1:0] stat_data,
   output logic              float_bus
);

   if (ADDR_W < 12) begin : g_bad_aw
      $error("lcbank_ctrl: ADDR_W too small");
   end

   lcb_mode_t mode_q;
   logic      sw_hit;

   lcb_mode_reg #(
      .ADDR_W    (ADDR_W),
      .SW_BASE   (SW_BASE),
      .RESET_MODE(RESET_MODE)
   ) u_mode (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_valid(bus_valid),
      .bus_addr (bus_addr),
      .sw_hit   (sw_hit),
      .mode_q   (mode_q)
   );

   lcb_map #(
      .ADDR_W   (ADDR_W),
      .WIN_BASE (WIN_BASE),
      .BANK_SPAN(BANK_SPAN)
   ) u_map (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_valid(bus_valid),
      .bus_we   (bus_we),
      .bus_addr (bus_addr),
      .alt_sel  (alt_sel),
      .mode_q   (mode_q),
      .rom_sel  (rom_sel),
      .ram_re   (ram_re),
      .ram_we   (ram_we),
      .ram_addr (ram_addr)
   );

   lcb_status #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .FLAG_BIT (FLAG_BIT),
      .BANK_STAT(BANK_STAT),
      .SRC_STAT (SRC_STAT)
   ) u_stat (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_valid(bus_valid),
      .bus_we   (bus_we),
      .bus_addr (bus_addr),
      .mode_q   (mode_q),
      .stat_hit (stat_hit),
      .stat_data(stat_data)
   );

   assign float_bus = bus_valid && !bus_we && sw_hit;

   AST_FLOAT_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
      float_bus |-> (!bus_we && !rom_sel && !ram_re && !ram_we && !stat_hit)); // R10

endmodule

// File: tb/lcbank_ctrl_tb.sv
module lcbank_ctrl_tb;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_valid = 1'b0;
   logic        bus_we = 1'b0;
   logic [15:0] bus_addr = 16'h0000;
   logic        alt_sel = 1'b0;
   logic        rom_sel, ram_re, ram_we, stat_hit, float_bus;
   logic [16:0] ram_addr;
   logic [7:0]  stat_data;

   int checks = 0;
   int failures = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   lcbank_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_we(bus_we),
      .bus_addr(bus_addr), .alt_sel(alt_sel), .rom_sel(rom_sel),
      .ram_re(ram_re), .ram_we(ram_we), .ram_addr(ram_addr),
      .stat_hit(stat_hit), .stat_data(stat_data), .float_bus(float_bus)
   );

   task automatic check(input string req, input int unsigned act, input int unsigned exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s addr=%h act=%0h exp=%0h", req, bus_addr, act, exp);
      end
   endtask

   // drive at the falling edge, sample a quarter period later
   task automatic drive(input logic v, input logic we, input logic [15:0] a, input logic alt);
      @(negedge clk);
      bus_valid = v; bus_we = we; bus_addr = a; alt_sel = alt;
      #(CLK_PERIOD/4);
   endtask

   // window checks for a mode value m (already masked)
   task automatic check_window(input logic [3:0] m, input logic [15:0] a,
                               input logic we, input logic alt, input string req);
      logic        rdram;
      logic [15:0] ph;
      rdram = (m[1] == m[0]);
      ph    = (m[3] && a < 16'hE000) ? a - 16'h1000 : a;
      drive(1'b1, we, a, alt);
      check({req, " R3 rom_sel"}, rom_sel, (!we && !rdram) ? 1 : 0);
      check({req, " R3 ram_re"},  ram_re,  (!we && rdram) ? 1 : 0);
      check({req, " R4 ram_we"},  ram_we,  (we && m[0]) ? 1 : 0);
      if (ram_re || ram_we)
         check({req, (a < 16'hE000) ? " R5 ram_addr" : " R6 ram_addr"}, ram_addr, {alt, ph});
      if (ram_re || ram_we)
         check({req, " R7 aux bit"}, ram_addr[16], alt);
   endtask

   task automatic check_status(input logic [3:0] m, input string req);
      drive(1'b1, 1'b0, 16'hC011, 1'b0);
      check({req, " R8 hit"}, stat_hit, 1);
      check({req, " R8 bank flag"}, stat_data, (m < 4) ? 8'h80 : 8'h00);
      drive(1'b1, 1'b0, 16'hC012, 1'b0);
      check({req, " R9 hit"}, stat_hit, 1);
      check({req, " R9 src flag"}, stat_data, (m[1] == m[0]) ? 8'h80 : 8'h00);
   endtask

   initial begin
      logic [15:0] taddr [5];
      taddr[0] = 16'hD000; taddr[1] = 16'hD5A3; taddr[2] = 16'hDFFF;
      taddr[3] = 16'hE000; taddr[4] = 16'hFFFF;

      // reset state (R2)
      repeat (3) @(posedge clk);
      check_window(4'b0010, 16'hD000, 1'b0, 1'b0, "R2 reset read");
      check_window(4'b0010, 16'hE123, 1'b1, 1'b0, "R2 reset write");
      check_status(4'b0010, "R2 reset");
      @(negedge clk);
      rst_n = 1'b1;

      // sweep every switch address as read and write
      for (int sw = 0; sw < 16; sw++) begin
         for (int swwe = 0; swwe < 2; swwe++) begin
            logic [3:0] m;
            m = 4'(sw) & 4'hB;
            drive(1'b1, swwe[0], 16'hC080 | 16'(sw), 1'b0);
            check("R10 float", float_bus, swwe[0] ? 0 : 1);
            check("R11 no window strobe", {rom_sel, ram_re, ram_we}, 0);
            for (int ti = 0; ti < 5; ti++)
               for (int we = 0; we < 2; we++)
                  for (int alt = 0; alt < 2; alt++)
                     check_window(m, taddr[ti], we[0], alt[0], "R1 sweep");
            check_status(m, "R1 sweep");
         end
      end

      // ignored accesses (R1, R11)
      drive(1'b1, 1'b1, 16'hC08B, 1'b0);           // mode 1011: bank1, RAM rd/wr
      drive(1'b1, 1'b1, 16'hC090, 1'b0);           // just above the switch block
      check("R10 float near miss", float_bus, 0);
      drive(1'b1, 1'b0, 16'hC07F, 1'b0);           // just below
      check("R10 float below", float_bus, 0);
      drive(1'b0, 1'b0, 16'hC080, 1'b0);           // idle cycle on a switch address
      check("R10 float idle", float_bus, 0);
      check("R11 idle quiet", {rom_sel, ram_re, ram_we}, 0);
      check_status(4'b1011, "R1 ignored");
      check_window(4'b1011, 16'hD010, 1'b1, 1'b1, "R1 ignored");
      drive(1'b0, 1'b1, 16'hD000, 1'b0);
      check("R11 invalid window", {rom_sel, ram_re, ram_we}, 0);
      drive(1'b1, 1'b0, 16'hCFFF, 1'b0);
      check("R11 below window", {rom_sel, ram_re, ram_we}, 0);
      check("R8 no stat elsewhere", stat_hit, 0);
      drive(1'b1, 1'b1, 16'hC011, 1'b0);
      check("R8 write not status", stat_hit, 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 200000);
      failures++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule